// File: doc/BRIEF.md
# Masked-Write GPIO Pad Controller

This block controls a bank of general-purpose pads, one control bit per pin in each of several register banks. Software reaches it through a plain 32-bit register port (address, write strobe, write data, combinational read data). Every writable word carries its own write-enable mask in the upper half-word. A write therefore changes only the control bits whose mask bits are set, and no read-modify-write sequence is needed when several agents share a word.

Each pad has three possible owners. A per-pin route bit hands the pad to a fully multiplexed peripheral. When that bit is set, a per-pin owner bit chooses between an I/O-processor port and the GPIO logic itself. Under GPIO control the driven value can be inverted, and open-drain behaviour is emulated by driving low only. Pad inputs pass through a two-flop synchronizer and can be inverted before software reads them.

Top module: `gpio_pad_ctrl`

## Requirements
- R1: Bank bases are owner 0x00, output enable 0x20, output value 0x40, input view 0x60, input invert 0x80, output invert 0xA0, open-drain 0xC0 and route 0xE0. Pin n is bit n%16 of the word at base + 4*(n/16).
- R2: In a write, control bit k of the addressed word changes only when bit k+16 of the write data is 1. All other control bits keep their value.
- R3: Writing bits k and k+16 both set makes control bit k equal 1. Writing bit k+16 set with bit k clear makes it 0.
- R4: Reads return 0 in bits 31:16. An address with bits 1:0 non-zero, or with a word index at or above NUM_PINS/16, reads 0, and a write to such an address changes nothing.
- R5: After reset every control bit reads 0.
- R6: With the route bit at 0, the pad output and pad enable follow periph_out_i and periph_oe_i for that pin.
- R7: With the route bit at 1 and the owner bit at 0, the pad output and pad enable follow iop_out_i and iop_oe_i.
- R8: With the route and owner bits at 1 and open-drain at 0, the pad output equals the output value XOR the output invert bit, and the pad enable equals the output-enable bit.
- R9: With the route and owner bits at 1 and open-drain at 1, the pad output is 0. The pad enable is 1 only when the output-enable bit is 1 and the output value XOR the output invert bit is 0.
- R10: The input view word returns the pad input XOR the input invert bit. A pad input change first appears in it after the second rising clock edge.
- R11: Writes to the input view bank have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 8 | Register byte address |
| we_i | input | 1 | Write strobe |
| wdata_i | input | 32 | Write data: mask in 31:16, control in 15:0 |
| rdata_o | output | 32 | Read data for addr_i |
| pad_in_i | input | NUM_PINS | Pad input levels |
| pad_out_o | output | NUM_PINS | Pad output values |
| pad_oe_o | output | NUM_PINS | Pad output enables |
| iop_out_i | input | NUM_PINS | I/O-processor output values |
| iop_oe_i | input | NUM_PINS | I/O-processor output enables |
| periph_out_i | input | NUM_PINS | Peripheral output values |
| periph_oe_i | input | NUM_PINS | Peripheral output enables |

## Verification
The bench sets and clears every pin in every writable bank, one pin at a time. A wrong half-word split or a wrong bank base shows up as a bit appearing in a neighbouring word. A partial-mask write catches a design that ignores the mask, which would overwrite unmasked bits. A full sweep of route, owner, enable, value, inversion and open-drain on a low pin and a high pin exposes a wrong ownership priority, and exposes an open-drain pad that drives high or enables at the wrong polarity. Input sampling is checked edge by edge, so a synchronizer one stage short or one stage long fails. Writes to the input bank and to unmapped addresses are checked to leave the read-back unchanged.

// File: rtl/gpio_pad_pkg.sv
package gpio_pad_pkg;
  localparam int CTRL_W = 16;
  localparam int DATA_W = 2 * CTRL_W;
  localparam int ADDR_W = 8;
  localparam int NBANK  = 8;

  typedef enum logic [2:0] {
    BANK_OWNER = 3'd0,
    BANK_OE    = 3'd1,
    BANK_OUT   = 3'd2,
    BANK_IN    = 3'd3,
    BANK_IINV  = 3'd4,
    BANK_OINV  = 3'd5,
    BANK_OD    = 3'd6,
    BANK_ROUTE = 3'd7
  } bank_e;
endpackage

// File: rtl/gpio_mask_reg.sv
module gpio_mask_reg
  import gpio_pad_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [CTRL_W-1:0] q_o
);
  logic [CTRL_W-1:0] q_q, mask, data;

  assign mask = wdata_i[DATA_W-1:CTRL_W];
  assign data = wdata_i[CTRL_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_q <= '0;
    else if (we_i) q_q <= (q_q & ~mask) | (data & mask);
  end

  assign q_o = q_q;

  a_r2_unmasked_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((q_q & ~($past(mask) & {CTRL_W{$past(we_i)}})) ==
              ($past(q_q) & ~($past(mask) & {CTRL_W{$past(we_i)}}))));

  a_r3_masked_take: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> ((q_q & $past(mask)) == ($past(data) & $past(mask))));
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/gpio_pad_mux.sv
module gpio_pad_mux #(
  parameter int NUM_PINS = 32
) (
  input  logic [NUM_PINS-1:0] route_i,
  input  logic [NUM_PINS-1:0] owner_i,
  input  logic [NUM_PINS-1:0] oe_i,
  input  logic [NUM_PINS-1:0] out_i,
  input  logic [NUM_PINS-1:0] oinv_i,
  input  logic [NUM_PINS-1:0] od_i,
  input  logic [NUM_PINS-1:0] iop_out_i,
  input  logic [NUM_PINS-1:0] iop_oe_i,
  input  logic [NUM_PINS-1:0] periph_out_i,
  input  logic [NUM_PINS-1:0] periph_oe_i,
  output logic [NUM_PINS-1:0] pad_out_o,
  output logic [NUM_PINS-1:0] pad_oe_o
);
  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    logic lvl;
    assign lvl = out_i[p] ^ oinv_i[p];

    always_comb begin
      if (!route_i[p]) begin
        pad_out_o[p] = periph_out_i[p];
        pad_oe_o[p]  = periph_oe_i[p];
      end else if (!owner_i[p]) begin
        pad_out_o[p] = iop_out_i[p];
        pad_oe_o[p]  = iop_oe_i[p];
      end else if (od_i[p]) begin
        // open drain: only ever pull low
        pad_out_o[p] = 1'b0;
        pad_oe_o[p]  = oe_i[p] & ~lvl;
      end else begin
        pad_out_o[p] = lvl;
        pad_oe_o[p]  = oe_i[p];
      end
    end
  end
endmodule

// File: rtl/gpio_pad_ctrl.sv
module gpio_pad_ctrl
  import gpio_pad_pkg::*;
#(
  parameter int NUM_PINS = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic                we_i,
  input  logic [DATA_W-1:0]   wdata_i,
  output logic [DATA_W-1:0]   rdata_o,
  input  logic [NUM_PINS-1:0] pad_in_i,
  output logic [NUM_PINS-1:0] pad_out_o,
  output logic [NUM_PINS-1:0] pad_oe_o,
  input  logic [NUM_PINS-1:0] iop_out_i,
  input  logic [NUM_PINS-1:0] iop_oe_i,
  input  logic [NUM_PINS-1:0] periph_out_i,
  input  logic [NUM_PINS-1:0] periph_oe_i
);
  localparam int WORDS = NUM_PINS / CTRL_W;

  logic [2:0] bank_sel, word_sel;
  logic       hit;

  assign bank_sel = addr_i[7:5];
  assign word_sel = addr_i[4:2];
  assign hit      = (addr_i[1:0] == 2'b00) && (int'(word_sel) < WORDS);

  logic [NBANK-1:0][NUM_PINS-1:0] bits;
  logic [NUM_PINS-1:0]            in_sync, in_view;

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    for (genvar w = 0; w < WORDS; w++) begin : g_word
      if (b == int'(BANK_IN)) begin : g_ro
        assign bits[b][w*CTRL_W +: CTRL_W] = '0;
      end else begin : g_rw
        gpio_mask_reg u_reg (
          .clk_i   (clk_i),
          .rst_ni  (rst_ni),
          .we_i    (we_i && hit && (bank_sel == 3'(b)) && (word_sel == 3'(w))),
          .wdata_i (wdata_i),
          .q_o     (bits[b][w*CTRL_W +: CTRL_W])
        );
      end
    end
  end

  gpio_in_sync #(.W(NUM_PINS)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pad_in_i),
    .q_o    (in_sync)
  );

  assign in_view = in_sync ^ bits[BANK_IINV];

  logic [CTRL_W-1:0] rd_ctrl;
  always_comb begin
    rd_ctrl = '0;
    for (int w = 0; w < WORDS; w++) begin
      if (hit && (word_sel == 3'(w))) begin
        if (bank_sel == BANK_IN) rd_ctrl = in_view[w*CTRL_W +: CTRL_W];
        else                     rd_ctrl = bits[bank_sel][w*CTRL_W +: CTRL_W];
      end
    end
  end

  assign rdata_o = {{(DATA_W-CTRL_W){1'b0}}, rd_ctrl};

  gpio_pad_mux #(.NUM_PINS(NUM_PINS)) u_mux (
    .route_i      (bits[BANK_ROUTE]),
    .owner_i      (bits[BANK_OWNER]),
    .oe_i         (bits[BANK_OE]),
    .out_i        (bits[BANK_OUT]),
    .oinv_i       (bits[BANK_OINV]),
    .od_i         (bits[BANK_OD]),
    .iop_out_i    (iop_out_i),
    .iop_oe_i     (iop_oe_i),
    .periph_out_i (periph_out_i),
    .periph_oe_i  (periph_oe_i),
    .pad_out_o    (pad_out_o),
    .pad_oe_o     (pad_oe_o)
  );

  logic [NUM_PINS-1:0] route_v, owner_v, od_v;
  assign route_v = bits[BANK_ROUTE];
  assign owner_v = bits[BANK_OWNER];
  assign od_v    = bits[BANK_OD];

  a_r6_periph_pass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pad_out_o & ~route_v) == (periph_out_i & ~route_v)) &&
    ((pad_oe_o & ~route_v) == (periph_oe_i & ~route_v)));

  a_r7_iop_pass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pad_oe_o & route_v & ~owner_v) == (iop_oe_i & route_v & ~owner_v)));

  a_r9_od_never_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pad_out_o & route_v & owner_v & od_v) == '0);
endmodule

// File: tb/gpio_pad_ctrl_tb_top.sv
module gpio_pad_ctrl_tb_top;
  localparam int NP = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [7:0]    addr = '0;
  logic          we = 1'b0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic [NP-1:0] pad_in = '0, pad_out, pad_oe;
  logic [NP-1:0] iop_out = 32'h5A5A_3C3C, iop_oe = 32'h0FF0_C3C3;
  logic [NP-1:0] per_out = 32'h9696_F00F, per_oe = 32'h6699_AA55;

  int n_run = 0, n_fail = 0;

  always #10 clk = ~clk;

  gpio_pad_ctrl #(.NUM_PINS(NP)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .we_i(we), .wdata_i(wdata),
    .rdata_o(rdata), .pad_in_i(pad_in), .pad_out_o(pad_out), .pad_oe_o(pad_oe),
    .iop_out_i(iop_out), .iop_oe_i(iop_oe), .periph_out_i(per_out), .periph_oe_i(per_oe)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] adr(input int bank, input int pin);
    return 8'(bank * 32 + (pin / 16) * 4);
  endfunction

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic put(input int bank, input int pin, input logic v);
    wr(adr(bank, pin), (32'h1 << (pin % 16 + 16)) | (32'(v) << (pin % 16)));
  endtask

  task automatic finish_run;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    #(20 * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] r;
    int wbanks[7] = '{0, 1, 2, 4, 5, 6, 7};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R5: all control words zero after reset; R6: pads follow peripheral
    for (int b = 0; b < 8; b++)
      for (int w = 0; w < 2; w++) begin
        if (b == 3) continue;
        rd(8'(b * 32 + w * 4), r);
        chk("R5 reset", r, 0);
      end
    chk("R6 reset out", pad_out, per_out);
    chk("R6 reset oe", pad_oe, per_oe);

    // R1, R3, R4: set and clear every pin in every writable bank
    foreach (wbanks[i]) begin
      for (int p = 0; p < NP; p++) begin
        put(wbanks[i], p, 1'b1);
        rd(adr(wbanks[i], p), r);
        chk("R3 set", r, 32'h1 << (p % 16));
        rd(adr(wbanks[i], (p + 16) % 32), r);
        chk("R1 other word", r, 0);
        put(wbanks[i], p, 1'b0);
        rd(adr(wbanks[i], p), r);
        chk("R3 clear", r, 0);
      end
    end

    // R2: partial mask
    wr(8'h40, 32'hFFFF_A5A5);
    wr(8'h40, 32'h0F0F_FFFF);
    rd(8'h40, r);
    chk("R2 partial mask", r, (32'hA5A5 & ~32'h0F0F) | 32'h0F0F);
    wr(8'h40, 32'h0000_0000);
    rd(8'h40, r);
    chk("R2 zero mask", r, 32'hAFAF);

    // R4: unmapped address reads zero, its write has no effect
    wr(8'h48, 32'hFFFF_0000);
    rd(8'h48, r);
    chk("R4 unmapped read", r, 0);
    rd(8'h40, r);
    chk("R4 unmapped write", r, 32'hAFAF);
    wr(8'h41, 32'hFFFF_0000);
    rd(8'h40, r);
    chk("R4 misaligned write", r, 32'hAFAF);
    wr(8'h40, 32'hFFFF_0000);
    rd(8'h40, r);
    chk("R4 upper zero", r[31:16], 0);

    // R6-R9: sweep all ownership/control combinations on two pins
    foreach (wbanks[j]) ;
    for (int k = 0; k < 2; k++) begin
      int p = (k == 0) ? 3 : 19;
      for (int c = 0; c < 64; c++) begin
        logic rt = c[0], ow = c[1], oe = c[2], ov = c[3], oi = c[4], od = c[5];
        logic eo, ee, lvl;
        put(7, p, rt); put(0, p, ow); put(1, p, oe);
        put(2, p, ov); put(5, p, oi); put(6, p, od);
        #1;
        lvl = ov ^ oi;
        if (!rt)      begin eo = per_out[p]; ee = per_oe[p]; end
        else if (!ow) begin eo = iop_out[p]; ee = iop_oe[p]; end
        else if (od)  begin eo = 1'b0;       ee = oe & ~lvl; end
        else          begin eo = lvl;        ee = oe;        end
        if (!rt)      begin chk("R6 out", 32'(pad_out[p]), 32'(eo)); chk("R6 oe", 32'(pad_oe[p]), 32'(ee)); end
        else if (!ow) begin chk("R7 out", 32'(pad_out[p]), 32'(eo)); chk("R7 oe", 32'(pad_oe[p]), 32'(ee)); end
        else if (od)  begin chk("R9 out", 32'(pad_out[p]), 32'(eo)); chk("R9 oe", 32'(pad_oe[p]), 32'(ee)); end
        else          begin chk("R8 out", 32'(pad_out[p]), 32'(eo)); chk("R8 oe", 32'(pad_oe[p]), 32'(ee)); end
      end
    end

    // R10: input view, inversion and two-edge latency
    wr(8'h80, 32'hFFFF_00FF);
    wr(8'h84, 32'hFFFF_F000);
    @(negedge clk);
    pad_in = 32'h1234_ABCD;
    repeat (3) @(negedge clk);
    rd(8'h60, r); chk("R10 low word", r, 32'hABCD ^ 32'h00FF);
    rd(8'h64, r); chk("R10 high word", r, 32'h1234 ^ 32'hF000);
    pad_in = 32'hCAFE_0F0F;
    rd(8'h60, r); chk("R10 edge0", r, 32'hABCD ^ 32'h00FF);
    @(negedge clk);
    rd(8'h60, r); chk("R10 edge1", r, 32'hABCD ^ 32'h00FF);
    @(negedge clk);
    rd(8'h60, r); chk("R10 edge2", r, 32'h0F0F ^ 32'h00FF);
    rd(8'h64, r); chk("R10 edge2 high", r, 32'hCAFE ^ 32'hF000);

    // R11: writes to the input bank are ignored
    wr(8'h60, 32'hFFFF_FFFF);
    rd(8'h60, r); chk("R11 in write ignored", r, 32'h0F0F ^ 32'h00FF);
    wr(8'h64, 32'hFFFF_0000);
    rd(8'h64, r); chk("R11 in write ignored high", r, 32'hCAFE ^ 32'hF000);
    rd(8'h80, r); chk("R11 invert kept", r, 32'h00FF);

    finish_run();
  end
endmodule